// File: doc/BRIEF.md
# Serial Port Receive/Transmit FIFO Controller

This block holds the receive and transmit byte queues of a 16550-style serial port and the host-writable FIFO control byte that manages them. The receive queue is filled by the receive shifter and drained by the host data port. The transmit queue is filled by the host and drained by the transmit shifter. Both queues report their occupancy.

A write to the control byte can flush either queue. A flush empties the queue and zeroes its counters but does not touch the shift registers, which sit outside this block. The flush request clears itself. The same write selects one of four receive trigger levels. A threshold flag is raised while the receive queue holds at least that many bytes. A push into a full receive queue is dropped and raises a sticky overrun flag.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A control write with bit 1 set empties the receive queue: on the next cycle `rx_count` is 0 and `rx_overrun` is 0, and the transmit queue is unchanged.
- R2: A control write with bit 2 set empties the transmit queue: on the next cycle `tx_count` is 0, and the receive queue is unchanged.
- R3: A flush acts only in the cycle of the write that requests it. No flush state is held, so a push in the very next cycle is stored normally.
- R4: Control bits 0, 3, 4 and 5 have no effect on either queue, its count, its output data or the flags.
- R5: Bits 7:6 of every control write set the receive trigger level: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. Reset selects 00.
- R6: `rx_thresh_hit` is 1 exactly while `rx_count` is greater than or equal to the selected trigger level. It follows the count with no added delay.
- R7: Each queue holds 16 bytes. A push while the queue is full is dropped. For the receive queue, such a push sets `rx_overrun`, which stays at 1 until a receive flush.
- R8: A pop from an empty queue leaves the count and the pop data output unchanged.
- R9: When a flush and a push to the same queue happen in the same cycle, the flush wins: the count ends at 0 and the byte is discarded.
- R10: Bytes leave each queue in the order they entered. Pop data appears on the pop data output one cycle after an accepted pop and is held until the next accepted pop.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged.
- R12: After reset, both counts are 0, both pop data outputs are 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte value |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | DATA_W | Byte from the receive shifter |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | DATA_W | Last byte popped from the receive queue |
| rx_count | output | CNT_W | Receive queue occupancy |
| rx_thresh_hit | output | 1 | Receive occupancy at or above trigger level |
| rx_overrun | output | 1 | Sticky: a byte was dropped on a full receive queue |
| tx_push | input | 1 | Host writes a byte to transmit |
| tx_push_data | input | DATA_W | Byte from the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | DATA_W | Last byte popped from the transmit queue |
| tx_count | output | CNT_W | Transmit queue occupancy |

## Verification
The bench goes after the cases where the queue is full. A push into a full queue that is not dropped would corrupt the oldest byte and push the count past 16. A missing overrun flag would hide the lost byte. The bench also covers a flush in the same cycle as a push. A design that let the push win would leave one stale byte and a count of 1. Each trigger level is tested at count = level−1 and count = level, where an off-by-one comparison shows up as a flag that is early or late. Writes that set only bits 0, 3, 4 or 5 show whether a decoder has wrongly tied a flush or the trigger field to the wrong bit. Pops on an empty queue show whether the count underflows or the data output is overwritten.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

   typedef enum logic [1:0] {
      TRIG_1B  = 2'b00,
      TRIG_4B  = 2'b01,
      TRIG_8B  = 2'b10,
      TRIG_14B = 2'b11
   } rx_trig_e;

   localparam int CTL_W          = 8;
   localparam int CTL_RX_FLUSH   = 1;
   localparam int CTL_TX_FLUSH   = 2;
   localparam int CTL_TRIG_LSB   = 6;
   localparam int MAX_TRIG_LEVEL = 14;

   function automatic int unsigned trig_level(input rx_trig_e sel);
      case (sel)
         TRIG_1B:  return 1;
         TRIG_4B:  return 4;
         TRIG_8B:  return 8;
         default:  return 14;
      endcase
   endfunction

endpackage

// File: rtl/fifo_ctl_decode.sv
module fifo_ctl_decode
   import uart_fifo_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] data,
   output logic             rx_flush,
   output logic             tx_flush,
   output rx_trig_e         trig_sel
);

   // Flush requests live for the write cycle only; nothing is stored.
   assign rx_flush = wr & data[CTL_RX_FLUSH];
   assign tx_flush = wr & data[CTL_TX_FLUSH];

   // Bits 0, 3, 4, 5 carry no function.
   logic unused_bits;
   assign unused_bits = ^{data[5:3], data[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trig_sel <= TRIG_1B;
      else if (wr)
         trig_sel <= rx_trig_e'(data[CTL_TRIG_LSB +: 2]);
   end

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 16,
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count,
   output logic              push_drop
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit               POW2     = (DEPTH & (DEPTH - 1)) == 0;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              full, empty, push_ok, pop_ok;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;
   assign push_drop = push & full & ~flush;

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok)
         mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         pop_data <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok) begin
            rd_ptr   <= rd_nxt;
            pop_data <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rx_threshold.sv
module rx_threshold
   import uart_fifo_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] count,
   input  rx_trig_e         trig_sel,
   output logic             hit
);

   logic [CNT_W-1:0] level;

   always_comb begin
      level = CNT_W'(trig_level(trig_sel));
      hit   = (count >= level);
   end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
   import uart_fifo_pkg::*;
#(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_data,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_push_data,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_pop_data,
   output logic [CNT_W-1:0]  rx_count,
   output logic              rx_thresh_hit,
   output logic              rx_overrun,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_push_data,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_pop_data,
   output logic [CNT_W-1:0]  tx_count
);

   initial begin
      assert (DEPTH >= MAX_TRIG_LEVEL)
         else $error("DEPTH must reach the largest trigger level");
      assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
   end

   logic     rx_flush, tx_flush, rx_drop, tx_drop;
   rx_trig_e trig_sel;

   fifo_ctl_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .data     (cfg_data),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush),
      .trig_sel (trig_sel)
   );

   byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (rx_push),
      .push_data (rx_push_data),
      .pop       (rx_pop),
      .pop_data  (rx_pop_data),
      .count     (rx_count),
      .push_drop (rx_drop)
   );

   byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (tx_push),
      .push_data (tx_push_data),
      .pop       (tx_pop),
      .pop_data  (tx_pop_data),
      .count     (tx_count),
      .push_drop (tx_drop)
   );

   logic unused_tx_drop;
   assign unused_tx_drop = tx_drop;

   rx_threshold #(.CNT_W(CNT_W)) u_thr (
      .count    (rx_count),
      .trig_sel (trig_sel),
      .hit      (rx_thresh_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_overrun <= 1'b0;
      else if (rx_flush)
         rx_overrun <= 1'b0;
      else if (rx_drop)
         rx_overrun <= 1'b1;
   end

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [7:0]        cfg_data,
   input logic              rx_push,
   input logic              rx_pop,
   input logic [DATA_W-1:0] rx_pop_data,
   input logic [CNT_W-1:0]  rx_count,
   input logic              rx_thresh_hit,
   input logic              rx_overrun,
   input logic              tx_push,
   input logic              tx_pop,
   input logic [CNT_W-1:0]  tx_count
);

   logic rx_fl, tx_fl;
   assign rx_fl = cfg_wr & cfg_data[1];
   assign tx_fl = cfg_wr & cfg_data[2];

   // R1
   rx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fl |=> (rx_count == '0) && !rx_overrun);

   // R2
   tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fl |=> (tx_count == '0));

   // R7
   rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));

   // R7
   tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(DEPTH));

   // R7
   rx_overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !rx_fl && rx_count == CNT_W'(DEPTH)) |=> rx_overrun);

   // R6
   thresh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |-> !rx_thresh_hit);

   // R6
   thresh_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count >= CNT_W'(14)) |-> rx_thresh_hit);

   // R8
   rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_push && !rx_fl && rx_count == '0)
         |=> $stable(rx_pop_data) && (rx_count == '0));

   // R11
   rx_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_pop && !rx_fl && rx_count != '0 && rx_count != CNT_W'(DEPTH))
         |=> $stable(rx_count));

   // R11
   tx_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_pop && !tx_fl && tx_count != '0 && tx_count != CNT_W'(DEPTH))
         |=> $stable(tx_count));

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int DATA_W     = 8;
   localparam int CNT_W      = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [7:0]        cfg_data = '0;
   logic              rx_push = 1'b0, rx_pop = 1'b0;
   logic [DATA_W-1:0] rx_push_data = '0;
   logic [DATA_W-1:0] rx_pop_data;
   logic [CNT_W-1:0]  rx_count;
   logic              rx_thresh_hit, rx_overrun;
   logic              tx_push = 1'b0, tx_pop = 1'b0;
   logic [DATA_W-1:0] tx_push_data = '0;
   logic [DATA_W-1:0] tx_pop_data;
   logic [CNT_W-1:0]  tx_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (.*);

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 0;
   string cur_tag = "R12";

   // reference state
   logic [7:0] m_rxq[$];
   logic [7:0] m_txq[$];
   logic [7:0] m_rx_last = '0, m_tx_last = '0;
   logic       m_ovr = 1'b0;
   logic [1:0] m_trig = 2'b00;

   function automatic int level_of(input logic [1:0] s);
      case (s)
         2'b00: return 1;
         2'b01: return 4;
         2'b10: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic check(input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
      end
   endtask

   task automatic model_step(input logic cw, input logic [7:0] cd,
                             input logic rpu, input logic [7:0] rpd, input logic rpo,
                             input logic tpu, input logic [7:0] tpd, input logic tpo);
      if (cw) m_trig = cd[7:6];
      if (cw && cd[1]) begin
         m_rxq.delete();
         m_ovr = 1'b0;
      end else begin
         int sz = m_rxq.size();
         if (rpu && sz == DEPTH) m_ovr = 1'b1;
         if (rpo && sz > 0) m_rx_last = m_rxq.pop_front();
         if (rpu && sz < DEPTH) m_rxq.push_back(rpd);
      end
      if (cw && cd[2]) begin
         m_txq.delete();
      end else begin
         int sz = m_txq.size();
         if (tpo && sz > 0) m_tx_last = m_txq.pop_front();
         if (tpu && sz < DEPTH) m_txq.push_back(tpd);
      end
   endtask

   task automatic compare_all();
      check("rx_count", int'(rx_count), m_rxq.size());
      check("tx_count", int'(tx_count), m_txq.size());
      check("rx_pop_data", int'(rx_pop_data), int'(m_rx_last));
      check("tx_pop_data", int'(tx_pop_data), int'(m_tx_last));
      check("rx_thresh_hit", int'(rx_thresh_hit),
            int'(m_rxq.size() >= level_of(m_trig)));
      check("rx_overrun", int'(rx_overrun), int'(m_ovr));
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input logic cw, input logic [7:0] cd,
                      input logic rpu, input logic [7:0] rpd, input logic rpo,
                      input logic tpu, input logic [7:0] tpd, input logic tpo);
      cfg_wr = cw; cfg_data = cd;
      rx_push = rpu; rx_push_data = rpd; rx_pop = rpo;
      tx_push = tpu; tx_push_data = tpd; tx_pop = tpo;
      @(posedge clk);
      model_step(cw, cd, rpu, rpd, rpo, tpu, tpd, tpo);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      cyc(1'b1, v, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic rx_in(input logic [7:0] v);
      cyc(1'b0, 8'h00, 1'b1, v, 1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic rx_out();
      cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
   end

   initial begin
      void'($urandom(32'h0005_1c3d));
      repeat (3) @(negedge clk);
      // R12: reset state
      cur_tag = "R12";
      compare_all();
      rst_n = 1'b1;
      idle();

      // R10: ordering, R8 empty pop
      cur_tag = "R10";
      for (int i = 0; i < 5; i++) rx_in(8'hA0 + 8'(i));
      for (int i = 0; i < 5; i++) rx_out();
      cur_tag = "R8";
      rx_out();
      rx_out();

      // R5 / R6: each trigger level at level-1 and level
      for (int s = 0; s < 4; s++) begin
         cur_tag = "R5";
         wr_ctl({2'(s), 6'b000010});
         cur_tag = "R6";
         for (int i = 0; i < level_of(2'(s)); i++) rx_in(8'(s * 16 + i));
         rx_out();
         cur_tag = "R6";
         rx_in(8'h55);
      end

      // R7: fill to full, push more, then overrun stays
      cur_tag = "R7";
      wr_ctl(8'b1100_0010);
      for (int i = 0; i < DEPTH + 3; i++) rx_in(8'(8'h30 + i));
      rx_out();
      idle();

      // R4: bits 0,3,4,5 only, trigger kept at 11
      cur_tag = "R4";
      wr_ctl(8'b1111_1001);
      wr_ctl(8'b1100_0001);

      // R1 with transmit untouched; R2 with receive untouched
      for (int i = 0; i < 3; i++)
         cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'(8'h70 + i), 1'b0);
      cur_tag = "R1";
      wr_ctl(8'b0000_0010);
      rx_in(8'h11);
      rx_in(8'h12);
      cur_tag = "R2";
      wr_ctl(8'b0000_0100);

      // R9: flush and push together on each queue
      cur_tag = "R9";
      cyc(1'b1, 8'b0000_0110, 1'b1, 8'hEE, 1'b0, 1'b1, 8'hDD, 1'b0);
      // R3: push right after the flush lands normally
      cur_tag = "R3";
      cyc(1'b0, 8'h00, 1'b1, 8'h21, 1'b0, 1'b1, 8'h22, 1'b0);
      idle();

      // R11: simultaneous push and pop mid-queue
      cur_tag = "R11";
      rx_in(8'h31);
      cyc(1'b0, 8'h00, 1'b1, 8'h32, 1'b1, 1'b1, 8'h33, 1'b1);
      cyc(1'b0, 8'h00, 1'b1, 8'h34, 1'b1, 1'b1, 8'h35, 1'b1);

      // random phases
      cur_tag = "R10 random";
      for (int ph = 0; ph < 30; ph++) begin
         int push_pct = (ph % 2 == 0) ? 75 : 30;
         for (int c = 0; c < 120; c++) begin
            logic cw = ($urandom_range(99) < 4);
            cyc(cw, 8'($urandom()),
                ($urandom_range(99) < push_pct), 8'($urandom()),
                ($urandom_range(99) >= push_pct),
                ($urandom_range(99) < push_pct), 8'($urandom()),
                ($urandom_range(99) >= push_pct));
         end
      end

      idle();
      finish_run();
   end

endmodule